// File: doc/BRIEF.md
# Per-CPU Interrupt Level Aggregator

One copy of this block sits beside each processor. It keeps a local pending word that holds three kinds of state. Software-raised interrupts sit in bits [31:17]. A level-15 broadcast bit sits in bit 15, and the CPU's own timer bit sits in bit 14. The block combines that word with the hard-interrupt levels handed down by the system-wide master controller. From the result it drives fifteen registered request lines, one for each priority level from 1 to 15, to its processor.

Software reaches the block through a narrow 32-bit access port addressed by word offset. Offset 0 reads the pending word. Offset 1 clears bits and offset 2 sets bits. When this CPU is the master's current target, the pending word read back also shows which hard levels the master currently holds raw.

Top module: `lic_cpu_agg`

## Requirements
- R1: A read (access enabled, write low) at offset 0 returns the pending word. Any other offset, or no read, gives zero on the read data.
- R2: A write at offset 1 clears every pending bit whose write-data bit is set, restricted to bits [31:17] and bit 15. Bit 14 and the hard display bits are not touched.
- R3: A write at offset 2 sets every pending bit in [31:17] whose write-data bit is set. Writes at offsets 0 and 3 change nothing.
- R4: Pending bit 16+L (L = 1..15) raises request line L whatever the master disable and target inputs are.
- R5: Pending bit 14 raises request line 14, and pending bit 15 raises request line 15, only while the master disable input is low.
- R6: Pending bit 14 takes the value of the timer input sampled at each clock edge.
- R7: A rising edge of the level-15 broadcast sets pending bit 15 and a falling edge clears it. An edge takes precedence over an offset-1 clear in the same cycle.
- R8: While the target input is high, pending bits [13:1] show the raw hard-level vector sampled at the previous edge. They read as zero otherwise, and they are rebuilt on every cycle. Bits 0 and 16 always read as zero.
- R9: An enabled hard level L raises request line L only while the target input is high and the master disable input is low.
- R10: After reset the pending word is zero and all request lines are low.
- R11: The request lines change one clock after the pending word or the hard inputs that feed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_off_i | input | 2 | Word offset |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data |
| is_tgt_i | input | 1 | This CPU is the master's target |
| mstr_dis_i | input | 1 | Master disable flag |
| hard_en_i | input | 15 | Enabled hard levels [15:1] from the master |
| hard_raw_i | input | 13 | Raw hard levels [13:1] from the master, for display |
| lvl15_i | input | 1 | Level-15 broadcast |
| timer_i | input | 1 | Local timer line |
| req_o | output | 15 | Request lines for levels [15:1] |

## Verification
The hardest case to reach is an offset-1 clear of bit 15 that lands in the same cycle as an edge on the level-15 broadcast. The same applies to the hard display bits changing while the master disable is set. The stimulus builds both on purpose. It holds a clear write open across a broadcast edge, and it toggles the target input while the disable input is high, so that the display moves but the request lines do not. A long mixed phase then drives all inputs together, and the reference model is compared on every clock.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int DW         = 32;
  localparam int NUM_LVL    = 15;
  localparam int SOFT_SHIFT = 16;
  localparam int DISP_TOP   = 13;
  localparam int TMR_BIT    = 14;
  localparam int L15_BIT    = 15;
  localparam logic [DW-1:0] SOFT_MASK = 32'hFFFE_0000;
  localparam logic [DW-1:0] CLR_MASK  = SOFT_MASK | (32'h1 << L15_BIT);
  localparam logic [DW-1:0] LOC_MASK  = CLR_MASK | (32'h1 << TMR_BIT);

  typedef enum logic [1:0] {
    OFF_PEND = 2'd0,
    OFF_CLR  = 2'd1,
    OFF_SET  = 2'd2,
    OFF_RSV  = 2'd3
  } off_e;
endpackage

// File: rtl/lic_pend_reg.sv
module lic_pend_reg
  import lic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_clr_i,
  input  logic               wr_set_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               timer_i,
  input  logic               lvl15_i,
  input  logic               is_tgt_i,
  input  logic [DISP_TOP:1]  hard_raw_i,
  output logic [DW-1:0]      pend_o
);
  logic [DW-1:0]     loc_q, loc_d;
  logic [DISP_TOP:1] disp_q;
  logic              l15_prev_q;
  logic              l15_rise, l15_fall;

  assign l15_rise = lvl15_i & ~l15_prev_q;
  assign l15_fall = ~lvl15_i & l15_prev_q;

  always_comb begin
    loc_d = loc_q;
    if (wr_set_i) loc_d = loc_d | (wdata_i & SOFT_MASK);
    if (wr_clr_i) loc_d = loc_d & ~(wdata_i & CLR_MASK);
    // broadcast edges win over a same-cycle clear
    if (l15_rise) loc_d[L15_BIT] = 1'b1;
    if (l15_fall) loc_d[L15_BIT] = 1'b0;
    loc_d[TMR_BIT] = timer_i;
    loc_d = loc_d & LOC_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q      <= '0;
      disp_q     <= '0;
      l15_prev_q <= 1'b0;
    end else begin
      loc_q      <= loc_d;
      disp_q     <= is_tgt_i ? hard_raw_i : '0;
      l15_prev_q <= lvl15_i;
    end
  end

  assign pend_o = loc_q | {{(DW-DISP_TOP-1){1'b0}}, disp_q, 1'b0};
endmodule

// File: rtl/lic_req_merge.sv
module lic_req_merge
  import lic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL:1]   soft_lvl_i,
  input  logic               tmr_bit_i,
  input  logic               l15_bit_i,
  input  logic [NUM_LVL:1]   hard_en_i,
  input  logic               is_tgt_i,
  input  logic               mstr_dis_i,
  output logic [NUM_LVL:1]   req_o
);
  logic hard_ok;
  assign hard_ok = is_tgt_i & ~mstr_dis_i;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    logic src;
    logic line_q;
    if (l == TMR_BIT) begin : g_tmr
      assign src = soft_lvl_i[l] | (hard_ok & hard_en_i[l]) | (tmr_bit_i & ~mstr_dis_i);
    end else if (l == L15_BIT) begin : g_l15
      assign src = soft_lvl_i[l] | (hard_ok & hard_en_i[l]) | (l15_bit_i & ~mstr_dis_i);
    end else begin : g_plain
      assign src = soft_lvl_i[l] | (hard_ok & hard_en_i[l]);
    end
    // line toggles only on change
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            line_q <= 1'b0;
      else if (src != line_q) line_q <= src;
    end
    assign req_o[l] = line_q;
  end
endmodule

// File: rtl/lic_cpu_agg.sv
module lic_cpu_agg
  import lic_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_en_i,
  input  logic                acc_we_i,
  input  logic [OFF_W-1:0]    acc_off_i,
  input  logic [DW-1:0]       acc_wdata_i,
  output logic [DW-1:0]       acc_rdata_o,
  input  logic                is_tgt_i,
  input  logic                mstr_dis_i,
  input  logic [NUM_LVL:1]    hard_en_i,
  input  logic [DISP_TOP:1]   hard_raw_i,
  input  logic                lvl15_i,
  input  logic                timer_i,
  output logic [NUM_LVL:1]    req_o
);
  logic [DW-1:0] pend;
  logic          wr_clr, wr_set, rd_pend;

  assign wr_clr  = acc_en_i & acc_we_i  & (acc_off_i == OFF_W'(OFF_CLR));
  assign wr_set  = acc_en_i & acc_we_i  & (acc_off_i == OFF_W'(OFF_SET));
  assign rd_pend = acc_en_i & ~acc_we_i & (acc_off_i == OFF_W'(OFF_PEND));

  lic_pend_reg u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_clr_i   (wr_clr),
    .wr_set_i   (wr_set),
    .wdata_i    (acc_wdata_i),
    .timer_i    (timer_i),
    .lvl15_i    (lvl15_i),
    .is_tgt_i   (is_tgt_i),
    .hard_raw_i (hard_raw_i),
    .pend_o     (pend)
  );

  lic_req_merge u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_lvl_i (pend[DW-1:SOFT_SHIFT+1]),
    .tmr_bit_i  (pend[TMR_BIT]),
    .l15_bit_i  (pend[L15_BIT]),
    .hard_en_i  (hard_en_i),
    .is_tgt_i   (is_tgt_i),
    .mstr_dis_i (mstr_dis_i),
    .req_o      (req_o)
  );

  assign acc_rdata_o = rd_pend ? pend : '0;
endmodule

// File: rtl/lic_cpu_agg_chk.sv
module lic_cpu_agg_chk
  import lic_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_en_i,
  input logic              acc_we_i,
  input logic [1:0]        acc_off_i,
  input logic [DW-1:0]     acc_wdata_i,
  input logic [DW-1:0]     acc_rdata_o,
  input logic              timer_i,
  input logic              mstr_dis_i,
  input logic [NUM_LVL:1]  req_o,
  input logic [DW-1:0]     pend
);
  AST_RD_OTHER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_off_i != 2'd0) |-> (acc_rdata_o == '0)); // R1

  AST_CLR_SOFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_we_i && acc_off_i == 2'd1)
      |=> ((pend & $past(acc_wdata_i) & SOFT_MASK) == '0)); // R2

  AST_SET_SOFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_we_i && acc_off_i == 2'd2)
      |=> ((pend & $past(acc_wdata_i) & SOFT_MASK) == ($past(acc_wdata_i) & SOFT_MASK))); // R3

  AST_SOFT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_o & $past(pend[DW-1:SOFT_SHIFT+1])) == $past(pend[DW-1:SOFT_SHIFT+1]))); // R4

  AST_DIS_GATES_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstr_dis_i |=> (req_o[TMR_BIT] == $past(pend[TMR_BIT+SOFT_SHIFT]) &&
                    req_o[L15_BIT] == $past(pend[L15_BIT+SOFT_SHIFT]))); // R5

  AST_TMR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend[TMR_BIT] == $past(timer_i))); // R6
endmodule

bind lic_cpu_agg lic_cpu_agg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_off_i   (acc_off_i),
  .acc_wdata_i (acc_wdata_i),
  .acc_rdata_o (acc_rdata_o),
  .timer_i     (timer_i),
  .mstr_dis_i  (mstr_dis_i),
  .req_o       (req_o),
  .pend        (pend)
);

// File: tb/lic_cpu_agg_tb.sv
module lic_cpu_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [1:0]  acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        is_tgt = 1'b0, mstr_dis = 1'b0, lvl15 = 1'b0, timer = 1'b0;
  logic [15:1] hard_en = '0;
  logic [13:1] hard_raw = '0;
  logic [15:1] req;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  lic_cpu_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_off_i(acc_off),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .is_tgt_i(is_tgt), .mstr_dis_i(mstr_dis),
    .hard_en_i(hard_en), .hard_raw_i(hard_raw),
    .lvl15_i(lvl15), .timer_i(timer), .req_o(req)
  );

  // reference model
  logic [31:0] m_loc;
  logic [13:1] m_disp;
  logic        m_prev;
  logic [15:1] m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loc = '0; m_disp = '0; m_prev = 1'b0; m_req = '0;
    end else begin
      for (int l = 1; l <= 15; l++) begin
        m_req[l] = m_loc[l+16] || (is_tgt && !mstr_dis && hard_en[l]);
        if (l == 14 && !mstr_dis && m_loc[14]) m_req[l] = 1'b1;
        if (l == 15 && !mstr_dis && m_loc[15]) m_req[l] = 1'b1;
      end
      if (acc_en && acc_we && acc_off == 2) m_loc = m_loc | (acc_wdata & 32'hFFFE_0000);
      if (acc_en && acc_we && acc_off == 1) m_loc = m_loc & ~(acc_wdata & 32'hFFFE_8000);
      if (lvl15 && !m_prev) m_loc[15] = 1'b1;
      if (!lvl15 && m_prev) m_loc[15] = 1'b0;
      m_loc[14] = timer;
      m_disp = is_tgt ? hard_raw : '0;
      m_prev = lvl15;
    end
  end

  function automatic logic [31:0] exp_pend();
    return m_loc | {18'b0, m_disp, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  task automatic tick();
    logic [31:0] er;
    @(negedge clk);
    er = (acc_en && !acc_we && acc_off == 0) ? exp_pend() : 32'h0;
    check({cur_tag, " req"}, {17'b0, req}, {17'b0, m_req});
    check({cur_tag, " rdata"}, acc_rdata, er);
  endtask

  task automatic wr(input logic [1:0] off, input logic [31:0] d);
    acc_en = 1; acc_we = 1; acc_off = off; acc_wdata = d;
    tick();
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [1:0] off);
    acc_en = 1; acc_we = 0; acc_off = off;
    tick();
    acc_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    cur_tag = "R10";
    rd(0);
    check("R10 pend after reset", acc_rdata, 32'h0);
    check("R10 req after reset", {17'b0, req}, 32'h0);

    // R3 set and R1 reads
    cur_tag = "R3";
    wr(2, 32'hA5A5_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    cur_tag = "R1";
    for (int o = 0; o < 4; o++) rd(o[1:0]);
    acc_en = 0; acc_off = 0; tick();
    check("R1 no read gives zero", acc_rdata, 32'h0);
    // R4 soft lines after one cycle
    cur_tag = "R4";
    mstr_dis = 1; is_tgt = 1; tick(); tick();
    check("R4 soft levels under disable", {17'b0, req}, {17'b0, 15'h52D2});
    mstr_dis = 0; is_tgt = 0;

    // R2 clear
    cur_tag = "R2";
    wr(1, 32'h8001_FFFF);
    rd(0);
    wr(1, 32'hFFFF_FFFF);
    rd(0);
    check("R2 soft cleared", acc_rdata & 32'hFFFE_0000, 32'h0);

    // R6 timer and R5 disable
    cur_tag = "R6";
    for (int i = 0; i < 12; i++) begin timer = i[1]; rd(0); end
    cur_tag = "R5";
    timer = 1; tick(); tick();
    check("R5 timer line enabled", {31'b0, req[14]}, 32'h1);
    mstr_dis = 1; tick();
    check("R5 timer line gated", {31'b0, req[14]}, 32'h0);
    mstr_dis = 0; timer = 0; tick(); tick();

    // R7 broadcast edges, with clears in the same cycle
    cur_tag = "R7";
    lvl15 = 1; rd(0); rd(0);
    check("R7 rise sets bit15", acc_rdata & 32'h8000, 32'h8000);
    wr(1, 32'h0000_8000); rd(0);
    check("R7 clear drops bit15", acc_rdata & 32'h8000, 32'h0);
    lvl15 = 0; tick(); lvl15 = 1;
    wr(1, 32'h0000_8000); rd(0);
    check("R7 rise wins over clear", acc_rdata & 32'h8000, 32'h8000);
    mstr_dis = 1; tick(); tick(); mstr_dis = 0; tick(); tick();
    lvl15 = 0; rd(0); rd(0);
    check("R7 fall clears bit15", acc_rdata & 32'h8000, 32'h0);

    // R8 display and R9 hard routing
    cur_tag = "R8";
    hard_raw = 13'h1ABC; hard_en = 15'h7FFF;
    rd(0); is_tgt = 1; rd(0); rd(0);
    check("R8 display when target", acc_rdata & 32'h3FFE, {18'b0, 13'h1ABC, 1'b0});
    hard_raw = 13'h0003; rd(0);
    check("R8 display rebuilt", acc_rdata & 32'h3FFE, 32'h6);
    mstr_dis = 1; hard_raw = 13'h1555; rd(0); rd(0);
    cur_tag = "R9";
    check("R9 hard gated by disable", {17'b0, req}, 32'h0);
    mstr_dis = 0; tick(); tick();
    check("R9 hard routed to target", {17'b0, req}, {17'b0, 15'h7FFF});
    is_tgt = 0; tick(); tick();
    check("R9 hard dropped off target", {17'b0, req}, 32'h0);
    rd(0);
    check("R8 display zero off target", acc_rdata & 32'h3FFF, 32'h0);
    hard_en = '0;

    // R11 mixed traffic
    cur_tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      acc_en = $urandom_range(0, 1); acc_we = $urandom_range(0, 1);
      acc_off = 2'($urandom); acc_wdata = $urandom;
      is_tgt = ($urandom_range(0, 3) != 0); mstr_dis = ($urandom_range(0, 4) == 0);
      hard_en = 15'($urandom); hard_raw = 13'($urandom);
      if ($urandom_range(0, 7) == 0) lvl15 = ~lvl15;
      if ($urandom_range(0, 5) == 0) timer = ~timer;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule